// File: doc/BRIEF.md
# Link Speed Bring-Up Controller

This controller brings a serial link up in two stages. Software pulses `start`. The controller first limits the link to the lowest generation and enables training. It then waits for the link to report up. If the requested generation is two or higher, it then lifts the limit to generation 2, requests a directed speed change and, unless told the hardware never clears it, polls the speed-change bit until it drops. Finally it waits for the link to come back up. Starting at generation 1 keeps devices behind a switch from going undetected during initial training.

Every register change is a read-modify-write carried out over a simple request port, held until acknowledged. The register fabric behind that port is outside this block. If any step fails, the controller runs a receiver recovery pulse before it reports an error. The pulse sets the receiver data-enable and PLL-enable override bits, holds them for a programmable time, then clears them. The result stays on `done_ok` / `done_err` with the negotiated speed until the next start.

Top module: `lsb_bringup`

## Requirements
- R1: After an accepted `start`, the controller changes bits [3:0] of the register at `CAP_ADDR` to 1 by read-modify-write, keeping all other bits, before `train_en` rises.
- R2: `train_en` is raised once that write completes. Link-up is bit 4 of `link_dbg`. If link-up is not seen within `LINK_TMO` cycles, the run fails.
- R3: When `target_gen` is below 2, `done_ok` follows the first link-up with no access to the register at `SPD_ADDR`. `cur_speed` then holds `link_sts[19:16]` as sampled at link-up.
- R4: When `target_gen` is 2 or more, after the first link-up bits [3:0] at `CAP_ADDR` become 2, other bits kept. Then bit 17 at `SPD_ADDR` is set by read-modify-write, other bits kept.
- R5: After setting bit 17, the controller reads `SPD_ADDR` up to `POLL_MAX` times, with more than `POLL_GAP` cycles between reads. It stops at the first read showing bit 17 clear. If every read shows it set, the run fails.
- R6: With `dsc_sticky` high at start, no poll read of `SPD_ADDR` is made after the speed-change write.
- R7: On the generation-2 path, `done_ok` is reported only after link-up is seen again following the speed change. The same `LINK_TMO` limit applies, and expiry is a failure.
- R8: On any failure, bits 5 and 3 at `RXO_ADDR` are set by read-modify-write with all other bits kept. At least `RECOV_WAIT` cycles later both are cleared the same way. Only then does `done_err` rise.
- R9: `done_ok` and `done_err` are never both high. Each holds until the next start. A `start` while `busy` is ignored.
- R10: Once `reg_req` is raised, it stays high with `reg_addr`, `reg_we` and `reg_wdata` unchanged until the cycle `reg_ack` is seen. `reg_req` is only high while `busy`.
- R11: After reset, `busy`, `done_ok`, `done_err`, `train_en`, `reg_req` and `cur_speed` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a bring-up (taken when not busy) |
| target_gen | input | 2 | Requested generation; 2 or more enables the upgrade |
| dsc_sticky | input | 1 | Speed-change bit does not self-clear; skip polling |
| link_dbg | input | DATA_W | Debug status word; bit 4 is link-up |
| link_sts | input | DATA_W | Link status word; bits 19:16 are current speed |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | Request is a write |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | DATA_W | Write data |
| reg_ack | input | 1 | Access complete (read data valid) |
| reg_rdata | input | DATA_W | Read data |
| train_en | output | 1 | Link training enable |
| busy | output | 1 | Bring-up in progress |
| done_ok | output | 1 | Bring-up succeeded |
| done_err | output | 1 | Bring-up failed (after recovery pulse) |
| cur_speed | output | 4 | Speed reported on success |

## Verification
The bench builds the controller with `LINK_TMO`=40, `POLL_MAX`=4, `POLL_GAP`=3 and `RECOV_WAIT`=12, in place of limits sized for microseconds and milliseconds. With these values a training timeout, a poll that exhausts its budget and the full recovery hold each finish within a few dozen cycles. Every failure path can therefore be driven to completion and its register writes counted. The small poll budget also makes the boundary reachable where the bit is still set on the very last allowed read.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_CAP1, ST_TRAIN, ST_CAP2, ST_DSC, ST_POLL, ST_GAP,
        ST_RELINK, ST_OK, ST_RXSET, ST_RXWAIT, ST_RXCLR, ST_FAIL
    } bu_st_e;

    typedef enum logic [1:0] {RW_IDLE, RW_RD, RW_WR} rw_st_e;

    localparam int SPD_FIELD_W  = 4;
    localparam int LINK_UP_BIT  = 4;
    localparam int DSC_BIT      = 17;
    localparam int CUR_SPD_LSB  = 16;
    localparam int RX_DATA_BIT  = 5;
    localparam int RX_PLL_BIT   = 3;
endpackage

// File: rtl/lsb_timer.sv
module lsb_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R8
    timer_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(zero) |-> $past(load));
endmodule

// File: rtl/lsb_rmw.sv
module lsb_rmw
    import lsb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              rd_only,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] clr_mask,
    input  logic [DATA_W-1:0] set_mask,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              reg_req,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_ack,
    input  logic [DATA_W-1:0] reg_rdata
);
    typedef struct packed {
        rw_st_e            st;
        logic              rd_only;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] clr;
        logic [DATA_W-1:0] set;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } rw_t;

    rw_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            RW_IDLE: if (go) begin
                d.st      = RW_RD;
                d.rd_only = rd_only;
                d.we      = 1'b0;
                d.addr    = addr;
                d.clr     = clr_mask;
                d.set     = set_mask;
            end
            RW_RD: if (reg_ack) begin
                d.rdata = reg_rdata;
                if (q.rd_only) begin
                    d.st   = RW_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.st    = RW_WR;
                    d.we    = 1'b1;
                    d.wdata = (reg_rdata & ~q.clr) | q.set;
                end
            end
            RW_WR: if (reg_ack) begin
                d.st   = RW_IDLE;
                d.we   = 1'b0;
                d.done = 1'b1;
            end
            default: d.st = RW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done      = q.done;
    assign rdata     = q.rdata;
    assign reg_req   = (q.st != RW_IDLE);
    assign reg_we    = q.we;
    assign reg_addr  = q.addr;
    assign reg_wdata = q.wdata;

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) &&
                                   $stable(reg_we) && $stable(reg_wdata)));
endmodule

// File: rtl/lsb_bringup.sv
module lsb_bringup
    import lsb_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int CAP_ADDR   = 'h10,
    parameter int SPD_ADDR   = 'h20,
    parameter int RXO_ADDR   = 'h30,
    parameter int LINK_TMO   = 100000,
    parameter int POLL_MAX   = 200,
    parameter int POLL_GAP   = 5000,
    parameter int RECOV_WAIT = 125000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        target_gen,
    input  logic              dsc_sticky,
    input  logic [DATA_W-1:0] link_dbg,
    input  logic [DATA_W-1:0] link_sts,
    output logic              reg_req,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_ack,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              train_en,
    output logic              busy,
    output logic              done_ok,
    output logic              done_err,
    output logic [3:0]        cur_speed
);
    localparam int TMR_MAX0 = (LINK_TMO > POLL_GAP) ? LINK_TMO : POLL_GAP;
    localparam int TMR_MAX  = (TMR_MAX0 > RECOV_WAIT) ? TMR_MAX0 : RECOV_WAIT;
    localparam int TMR_W    = $clog2(TMR_MAX + 1);
    localparam int PC_W     = $clog2(POLL_MAX + 1);
    localparam logic [DATA_W-1:0] FIELD_MASK = DATA_W'((1 << SPD_FIELD_W) - 1);
    localparam logic [DATA_W-1:0] DSC_MASK   = DATA_W'(1) << DSC_BIT;
    localparam logic [DATA_W-1:0] RX_MASK    = (DATA_W'(1) << RX_DATA_BIT) |
                                               (DATA_W'(1) << RX_PLL_BIT);

    typedef struct packed {
        bu_st_e          st;
        logic            sent;
        logic            tgt2;
        logic            sticky;
        logic            train;
        logic [PC_W-1:0] polls;
        logic [3:0]      spd;
    } ctl_t;

    ctl_t c, n;

    logic              op_go, op_rd, op_done, op_state;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_clr, op_set, op_rdata;
    logic              tmr_load, tmr_zero;
    logic [TMR_W-1:0]  tmr_val;
    logic              link_up;
    logic [PC_W-1:0]   poll_nxt;

    assign link_up  = link_dbg[LINK_UP_BIT];
    assign poll_nxt = c.polls + PC_W'(1);

    always_comb begin
        n        = c;
        tmr_load = 1'b0;
        tmr_val  = '0;
        op_rd    = 1'b0;
        op_addr  = ADDR_W'(CAP_ADDR);
        op_clr   = '0;
        op_set   = '0;
        op_state = 1'b1;
        case (c.st)
            ST_CAP1:  begin op_clr = FIELD_MASK; op_set = DATA_W'(1); end
            ST_CAP2:  begin op_clr = FIELD_MASK; op_set = DATA_W'(2); end
            ST_DSC:   begin op_addr = ADDR_W'(SPD_ADDR); op_set = DSC_MASK; end
            ST_POLL:  begin op_addr = ADDR_W'(SPD_ADDR); op_rd = 1'b1; end
            ST_RXSET: begin op_addr = ADDR_W'(RXO_ADDR); op_set = RX_MASK; end
            ST_RXCLR: begin op_addr = ADDR_W'(RXO_ADDR); op_clr = RX_MASK; end
            default:  op_state = 1'b0;
        endcase

        op_go = op_state && !c.sent;
        if (op_go)   n.sent = 1'b1;
        if (op_done) n.sent = 1'b0;

        case (c.st)
            ST_IDLE, ST_OK, ST_FAIL: if (start) begin
                n.st     = ST_CAP1;
                n.tgt2   = (target_gen >= 2'd2);
                n.sticky = dsc_sticky;
                n.train  = 1'b0;
                n.polls  = '0;
                n.spd    = '0;
                n.sent   = 1'b0;
            end
            ST_CAP1: if (op_done) begin
                n.st     = ST_TRAIN;
                n.train  = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(LINK_TMO);
            end
            ST_TRAIN: begin
                if (link_up) begin
                    if (c.tgt2) begin
                        n.st = ST_CAP2;
                    end else begin
                        n.st  = ST_OK;
                        n.spd = link_sts[CUR_SPD_LSB +: 4];
                    end
                end else if (tmr_zero) begin
                    n.st = ST_RXSET;
                end
            end
            ST_CAP2: if (op_done) n.st = ST_DSC;
            ST_DSC: if (op_done) begin
                if (c.sticky) begin
                    n.st     = ST_RELINK;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(LINK_TMO);
                end else begin
                    n.st = ST_POLL;
                end
            end
            ST_POLL: if (op_done) begin
                if (!op_rdata[DSC_BIT]) begin
                    n.st     = ST_RELINK;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(LINK_TMO);
                end else begin
                    n.polls = poll_nxt;
                    if (poll_nxt >= PC_W'(POLL_MAX)) begin
                        n.st = ST_RXSET;
                    end else begin
                        n.st     = ST_GAP;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(POLL_GAP);
                    end
                end
            end
            ST_GAP: if (tmr_zero) n.st = ST_POLL;
            ST_RELINK: begin
                if (link_up) begin
                    n.st  = ST_OK;
                    n.spd = link_sts[CUR_SPD_LSB +: 4];
                end else if (tmr_zero) begin
                    n.st = ST_RXSET;
                end
            end
            ST_RXSET: if (op_done) begin
                n.st     = ST_RXWAIT;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(RECOV_WAIT);
            end
            ST_RXWAIT: if (tmr_zero) n.st = ST_RXCLR;
            ST_RXCLR:  if (op_done) n.st = ST_FAIL;
            default:   n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c    <= '0;
            c.st <= ST_IDLE;
        end else begin
            c <= n;
        end
    end

    lsb_rmw #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rmw (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (op_go),
        .rd_only   (op_rd),
        .addr      (op_addr),
        .clr_mask  (op_clr),
        .set_mask  (op_set),
        .done      (op_done),
        .rdata     (op_rdata),
        .reg_req   (reg_req),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_ack   (reg_ack),
        .reg_rdata (reg_rdata)
    );

    lsb_timer #(.W(TMR_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .val   (tmr_val),
        .zero  (tmr_zero)
    );

    wire unused_bits = ^{link_dbg, link_sts, op_rdata};

    assign train_en  = c.train;
    assign done_ok   = (c.st == ST_OK);
    assign done_err  = (c.st == ST_FAIL);
    assign busy      = !(c.st == ST_IDLE || c.st == ST_OK || c.st == ST_FAIL);
    assign cur_speed = c.spd;

    // R9
    result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_ok && done_err));

    // R10
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |-> busy);

    // R7
    ok_after_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_ok) |-> (train_en && $past(link_up)));

    // R5
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c.polls <= PC_W'(POLL_MAX));

    // R6
    sticky_nopoll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c.sticky |-> (c.polls == '0));
endmodule

// File: tb/sim_lsb_bringup.sv
module sim_lsb_bringup;
    localparam int CAPA = 'h10, SPDA = 'h20, RXOA = 'h30;
    localparam int L_TMO = 40, P_MAX = 4, P_GAP = 3, R_WAIT = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, dsc_sticky = 1'b0;
    logic [1:0] target_gen = 2'd0;
    logic [31:0] link_dbg, link_sts;
    logic reg_req, reg_we, reg_ack;
    logic [7:0] reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic train_en, busy, done_ok, done_err;
    logic [3:0] cur_speed;

    always #10 clk = ~clk;

    lsb_bringup #(.ADDR_W(8), .DATA_W(32), .CAP_ADDR(CAPA), .SPD_ADDR(SPDA),
        .RXO_ADDR(RXOA), .LINK_TMO(L_TMO), .POLL_MAX(P_MAX), .POLL_GAP(P_GAP),
        .RECOV_WAIT(R_WAIT)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .target_gen(target_gen),
        .dsc_sticky(dsc_sticky), .link_dbg(link_dbg), .link_sts(link_sts),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
        .train_en(train_en), .busy(busy), .done_ok(done_ok),
        .done_err(done_err), .cur_speed(cur_speed));

    // configuration, written only by tasks
    logic [31:0] cfg_cap, cfg_spd, cfg_rxo;
    int cfg_clr_after;
    bit cfg_drop, cfg_relink, cfg_allow, cfg_tog = 1'b0;
    logic [3:0] cfg_speed = 4'd1;

    // model state, written only by the model process
    logic [31:0] mem_cap, mem_spd, mem_rxo, spd_last_w, cap_at_train;
    logic [31:0] rxo_w0, rxo_w1;
    int spd_pend, lcnt, cyc = 0;
    int cap_wr_n, spd_rd_n, spd_wr_n, rxo_wr_n;
    int rxo_t0, rxo_t1, last_rd_t, min_gap, link_t, ok_t;
    bit link, link_allow, cfg_seen = 1'b0, train_q, ok_q;

    assign link_dbg = {27'h0, link, 4'h0};
    assign link_sts = {12'h0, cfg_speed, 16'h5A5A};

    always @(posedge clk) begin
        cyc <= cyc + 1;
        train_q <= train_en;
        ok_q    <= done_ok;
        if (train_en && !train_q) cap_at_train <= mem_cap;
        if (done_ok && !ok_q) ok_t <= cyc;
        if (!rst_n) begin
            reg_ack <= 1'b0; reg_rdata <= '0; link <= 1'b0; lcnt <= 0;
        end else begin
            reg_ack <= reg_req && !reg_ack;
            if (!train_en) begin
                link <= 1'b0; lcnt <= 0;
            end else if (!link && link_allow) begin
                if (lcnt == 5) begin link <= 1'b1; link_t <= cyc; end
                else lcnt <= lcnt + 1;
            end
            if (cfg_tog != cfg_seen) begin
                cfg_seen <= cfg_tog;
                mem_cap <= cfg_cap; mem_spd <= cfg_spd; mem_rxo <= cfg_rxo;
                link_allow <= cfg_allow; spd_pend <= 0;
                cap_wr_n <= 0; spd_rd_n <= 0; spd_wr_n <= 0; rxo_wr_n <= 0;
                min_gap <= 1000; link_t <= 0; ok_t <= 0;
            end else if (reg_req && !reg_ack) begin
                if (reg_we) begin
                    if (reg_addr == 8'(CAPA)) begin
                        mem_cap <= reg_wdata; cap_wr_n <= cap_wr_n + 1;
                    end else if (reg_addr == 8'(SPDA)) begin
                        mem_spd <= reg_wdata; spd_last_w <= reg_wdata;
                        spd_wr_n <= spd_wr_n + 1;
                        if (reg_wdata[17]) begin
                            spd_pend <= cfg_clr_after;
                            if (cfg_drop) begin
                                link <= 1'b0; lcnt <= 0; link_allow <= cfg_relink;
                            end
                        end
                    end else if (reg_addr == 8'(RXOA)) begin
                        mem_rxo <= reg_wdata; rxo_wr_n <= rxo_wr_n + 1;
                        if (rxo_wr_n == 0) begin rxo_w0 <= reg_wdata; rxo_t0 <= cyc; end
                        else begin rxo_w1 <= reg_wdata; rxo_t1 <= cyc; end
                    end
                end else begin
                    if (reg_addr == 8'(CAPA)) reg_rdata <= mem_cap;
                    else if (reg_addr == 8'(RXOA)) reg_rdata <= mem_rxo;
                    else if (reg_addr == 8'(SPDA)) begin
                        reg_rdata <= mem_spd;
                        spd_rd_n <= spd_rd_n + 1;
                        last_rd_t <= cyc;
                        if (spd_rd_n >= 2 && (cyc - last_rd_t) < min_gap)
                            min_gap <= cyc - last_rd_t;
                        if (mem_spd[17] && spd_pend > 0) begin
                            spd_pend <= spd_pend - 1;
                            if (spd_pend == 1) mem_spd[17] <= 1'b0;
                        end
                    end else reg_rdata <= '0;
                end
            end
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic setup(logic [31:0] cap, logic [31:0] spd, logic [31:0] rxo,
                         int clr_after, bit drop, bit relink, bit allow);
        cfg_cap = cap; cfg_spd = spd; cfg_rxo = rxo; cfg_clr_after = clr_after;
        cfg_drop = drop; cfg_relink = relink; cfg_allow = allow;
        cfg_tog = ~cfg_tog;
        repeat (2) @(negedge clk);
    endtask

    task automatic run(logic [1:0] tgt, bit sticky, bit mid_start);
        @(negedge clk);
        target_gen = tgt; dsc_sticky = sticky; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (mid_start) begin
            repeat (4) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 3000 && !(done_ok || done_err); i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R11 outputs after reset",
            {busy, done_ok, done_err, train_en, reg_req, cur_speed}, '0);
    endtask

    task automatic t_gen1;
        cfg_speed = 4'd1;
        setup(32'h1234_5673, 32'h0000_0003, 32'hF0, 2, 0, 1, 1);
        run(2'd1, 1'b0, 1'b0);
        chk("R1 cap field at train rise", cap_at_train, 32'h1234_5671);
        chk("R2 train_en high", train_en, 1);
        chk("R3 ok/err", {done_ok, done_err}, 2'b10);
        chk("R3 cur_speed", cur_speed, 4'd1);
        chk("R3 no speed reg access", spd_rd_n + spd_wr_n, 0);
    endtask

    task automatic t_gen2;
        cfg_speed = 4'd2;
        setup(32'h1234_5673, 32'h0000_0003, 32'hF0, 2, 1, 1, 1);
        run(2'd2, 1'b0, 1'b0);
        chk("R4 cap field 2", mem_cap, 32'h1234_5672);
        chk("R4 speed ctl write", spd_last_w, 32'h0002_0003);
        chk("R5 poll reads", spd_rd_n - 1, 3);
        chk("R5 poll spacing", min_gap > P_GAP, 1);
        chk("R7 ok after relink", ok_t > link_t && link_t != 0, 1);
        chk("R3 ok and speed", {done_ok, done_err, cur_speed}, {2'b10, 4'd2});
    endtask

    task automatic t_stuck;
        setup(32'h0, 32'h0, 32'hF0, 0, 0, 1, 1);
        run(2'd2, 1'b0, 1'b0);
        chk("R5 poll budget exhausted", spd_rd_n - 1, P_MAX);
        chk("R5 failure reported", {done_ok, done_err}, 2'b01);
        chk("R8 recovery write count", rxo_wr_n, 2);
        chk("R8 first recovery write", rxo_w0, 32'hF8);
        chk("R8 second recovery write", rxo_w1, 32'hD0);
        chk("R8 hold time", (rxo_t1 - rxo_t0) >= R_WAIT, 1);
    endtask

    task automatic t_sticky;
        setup(32'h0, 32'h0, 32'h0, 0, 0, 1, 1);
        run(2'd3, 1'b1, 1'b0);
        chk("R6 no poll reads", spd_rd_n, 1);
        chk("R6 success", {done_ok, done_err}, 2'b10);
    endtask

    task automatic t_notrain;
        setup(32'h0, 32'h0, 32'h0, 0, 0, 1, 0);
        run(2'd2, 1'b0, 1'b0);
        chk("R2 timeout failure", {done_ok, done_err}, 2'b01);
        chk("R2 no speed access", spd_rd_n + spd_wr_n, 0);
        chk("R8 recovery writes", {rxo_w0, rxo_w1}, {32'h28, 32'h0});
    endtask

    task automatic t_relink_fail;
        setup(32'h0, 32'h0, 32'h0, 1, 1, 0, 1);
        run(2'd2, 1'b0, 1'b0);
        chk("R7 relink timeout failure", {done_ok, done_err}, 2'b01);
        chk("R7 recovery ran", rxo_wr_n, 2);
    endtask

    task automatic t_busy_start;
        cfg_speed = 4'd1;
        setup(32'h0, 32'h0, 32'h0, 0, 0, 1, 1);
        run(2'd1, 1'b0, 1'b1);
        chk("R9 start while busy ignored", cap_wr_n, 1);
        repeat (10) @(negedge clk);
        chk("R9 result held", {done_ok, done_err}, 2'b10);
        @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
        @(negedge clk);
        chk("R9 restart clears result", {done_ok, done_err, busy}, 3'b001);
        for (int i = 0; i < 3000 && !(done_ok || done_err); i++) @(negedge clk);
        chk("R9 restart completes", done_ok, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_gen1;
        t_gen2;
        t_stuck;
        t_sticky;
        t_notrain;
        t_relink_fail;
        t_busy_start;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule